// File: doc/BRIEF.md
# Byte-wide SPI master with two-step status clearing

This peripheral gives a small 8-bit controller one full-duplex SPI master channel behind a byte-wide register bus. Software programs a control byte that picks the serial clock rate, clock polarity and phase, and the bit order. A write to the data byte then sends eight bits on `mosi` while eight bits are captured from `miso`. The serial clock runs at one of four fixed fractions of the system clock. When the eighth bit has been handled, the captured byte replaces the data register and a completion flag rises. The flag can also drive an interrupt line.

The status flags clear without any write to the status register. Software first reads status while a flag is set, which marks that flag. Its next read or write of the data register then clears the marked flags. A write to the data register while a byte is still moving is refused, and it raises a write-collision flag. An acknowledge input clears the completion flag directly. The bus is a plain strobe interface with no back-pressure: a read returns data in the same cycle, and a write takes effect at the clock edge where the strobe is high.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control, status and data registers all read 0x00, `irq` is low and `sck` is low.
- R2: The control register is at BASE_ADDR (default 0x2D), status at BASE_ADDR+1 and data at BASE_ADDR+2. The control register reads back what was written. Reads of any other address return 0x00.
- R3: A data write while control bit 6 (enable) is 1 and no transfer is active starts a transfer of the written byte. When it completes, status bit 7 (complete) is 1 and the data register reads the byte received on `miso`.
- R4: Control bits [1:0] select the serial clock as the system clock divided by 4, 16, 64 or 128 for values 0, 1, 2 and 3. The complete flag is visible exactly 8×divisor cycles after the clock edge that accepted the data write.
- R5: Control bit 3 (polarity) sets the idle `sck` level. With control bit 2 (phase) at 0, bits are sampled on the leading edge; at 1, on the trailing edge. Control bit 5 at 0 sends and receives MSB first; at 1, LSB first.
- R6: A data write during an active transfer sets status bit 6 (collision). It changes neither the transfer in progress nor the byte finally loaded into the data register.
- R7: A status read that sees a flag set marks that flag. The next data-register read or write clears every marked flag. A data access with no prior marking status read leaves the flags set.
- R8: `irq` is high exactly when control bit 6 (enable), control bit 7 (interrupt enable) and the complete flag are all 1.
- R9: A high `irq_ack` at a clock edge clears the complete flag.
- R10: A data write with control bit 6 at 0 stores the byte, starts no transfer, leaves `sck` idle and sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; starts status marking and clearing side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle; 0x00 when not reading |
| irq_ack | input | 1 | Clears the complete flag |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench runs a slave model that samples and shifts on the edges that the chosen polarity and phase call for. A wrong phase or bit order therefore shows up as a corrupted byte on one side. It counts cycles from the accepting edge to the interrupt at every rate setting, so a divider that is off by a half period or a bit counter that is off by one gives a wrong count. It writes data in the middle of a transfer, which catches a design that restarts, corrupts or overwrites the shifting byte or that fails to raise the collision flag. It also probes the clearing sequence from both sides: a data read with no marking status read must leave the flag set, and the acknowledge input must clear it. A design with the marks wired wrong either clears too early or never clears.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

  localparam int BYTE_W = 8;

  // control register bit positions
  localparam int CB_RATE0  = 0;
  localparam int CB_RATE1  = 1;
  localparam int CB_PHASE  = 2;
  localparam int CB_POL    = 3;
  localparam int CB_MASTER = 4;
  localparam int CB_LSBF   = 5;
  localparam int CB_EN     = 6;
  localparam int CB_IE     = 7;

  // status register bit positions
  localparam int SB_COL  = 6;
  localparam int SB_DONE = 7;

  typedef struct packed {
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       lsb_first;
  } xfer_mode_t;

  // system clocks per half serial-clock period
  function automatic int half_period(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 8;
      2'd2:    return 32;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/spi_rate_tick.sv
module spi_rate_tick
  import spi_master_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(half_period(rate) - 1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // every half period is at least two system clocks
  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_master_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  xfer_mode_t        mode_in,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output xfer_mode_t        mode_q,
  output logic              sck_lvl,
  output logic              mosi
);

  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  logic              busy_q;
  logic [EW-1:0]     edge_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic              sck_q;
  xfer_mode_t        mode_r;

  logic              lead_edge;
  logic              first_edge;
  logic              last_edge;
  logic              sample_now;
  logic              shift_now;
  logic [DATA_W-1:0] rx_in;

  assign lead_edge  = ~edge_q[0];
  assign first_edge = (edge_q == '0);
  assign last_edge  = (edge_q == EW'(EDGES - 1));
  assign sample_now = tick && (mode_r.cpha ? !lead_edge : lead_edge);
  assign shift_now  = tick && (mode_r.cpha ? (lead_edge && !first_edge) : !lead_edge);
  assign rx_in      = mode_r.lsb_first ? {miso, rx_q[DATA_W-1:1]}
                                       : {rx_q[DATA_W-2:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
      mode_r <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      edge_q <= '0;
      tx_q   <= tx_byte;
      rx_q   <= '0;
      sck_q  <= mode_in.cpol;
      mode_r <= mode_in;
    end else if (busy_q && tick) begin
      sck_q  <= ~sck_q;
      edge_q <= edge_q + 1'b1;
      if (sample_now) rx_q <= rx_in;
      if (shift_now) begin
        tx_q <= mode_r.lsb_first ? (tx_q >> 1) : (tx_q << 1);
      end
      if (last_edge) busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign done    = busy_q && tick && last_edge;
  assign rx_byte = sample_now ? rx_in : rx_q;
  assign mode_q  = mode_r;
  assign sck_lvl = sck_q;
  assign mosi    = mode_r.lsb_first ? tx_q[0] : tx_q[DATA_W-1];

  assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  assert_done_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(mode_r));

endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic set_col,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic irq_ack,
  output logic done_f,
  output logic col_f
);

  logic done_q, col_q;
  logic mark_done_q, mark_col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q      <= 1'b0;
      col_q       <= 1'b0;
      mark_done_q <= 1'b0;
      mark_col_q  <= 1'b0;
    end else begin
      if (stat_rd) begin
        mark_done_q <= done_q;
        mark_col_q  <= col_q;
      end else if (data_acc || irq_ack) begin
        mark_done_q <= 1'b0;
        mark_col_q  <= mark_col_q && !data_acc;
      end
      // a new event wins over any clear in the same cycle
      if (set_done) begin
        done_q <= 1'b1;
      end else if (irq_ack || (data_acc && mark_done_q)) begin
        done_q <= 1'b0;
      end
      if (set_col) begin
        col_q <= 1'b1;
      end else if (data_acc && mark_col_q) begin
        col_q <= 1'b0;
      end
    end
  end

  assign done_f = done_q;
  assign col_f  = col_q;

  assert_marked_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !stat_rd && mark_done_q && !set_done) |=> !done_q);
  assert_unmarked_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !mark_done_q && !stat_rd && !irq_ack) |=> done_q);
  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !set_done) |=> !done_q);
  assert_col_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_col |=> col_q);

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_master_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h2D,
  parameter int              DIV_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              irq_ack,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = BASE_ADDR;
  localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(2);

  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] stat_byte;
  logic [BYTE_W-1:0] rx_byte;

  logic sel_ctrl, sel_stat, sel_data;
  logic data_wr, data_acc, start, collide;
  logic busy, done, tick, sck_lvl;
  logic done_f, col_f;
  xfer_mode_t mode_now, mode_q;

  assign sel_ctrl = (bus_addr == CTRL_ADDR);
  assign sel_stat = (bus_addr == STAT_ADDR);
  assign sel_data = (bus_addr == DATA_ADDR);

  assign data_wr  = bus_wr && sel_data;
  assign data_acc = (bus_wr || bus_rd) && sel_data;
  assign start    = data_wr && !busy && ctrl_q[CB_EN];
  assign collide  = data_wr && busy;

  assign mode_now.rate      = {ctrl_q[CB_RATE1], ctrl_q[CB_RATE0]};
  assign mode_now.cpha      = ctrl_q[CB_PHASE];
  assign mode_now.cpol      = ctrl_q[CB_POL];
  assign mode_now.lsb_first = ctrl_q[CB_LSBF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (bus_wr && sel_ctrl) ctrl_q <= bus_wdata;
      if (done) begin
        data_q <= rx_byte;
      end else if (data_wr && !busy) begin
        data_q <= bus_wdata;
      end
    end
  end

  spi_rate_tick #(.CNT_W(DIV_W)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .rate  (mode_q.rate),
    .tick  (tick)
  );

  spi_shift_engine #(.DATA_W(BYTE_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_byte (bus_wdata),
    .mode_in (mode_now),
    .tick    (tick),
    .miso    (miso),
    .busy    (busy),
    .done    (done),
    .rx_byte (rx_byte),
    .mode_q  (mode_q),
    .sck_lvl (sck_lvl),
    .mosi    (mosi)
  );

  spi_status_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_done (done),
    .set_col  (collide),
    .stat_rd  (bus_rd && sel_stat),
    .data_acc (data_acc),
    .irq_ack  (irq_ack),
    .done_f   (done_f),
    .col_f    (col_f)
  );

  always_comb begin
    stat_byte          = '0;
    stat_byte[SB_DONE] = done_f;
    stat_byte[SB_COL]  = col_f;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_ctrl)      bus_rdata = ctrl_q;
      else if (sel_stat) bus_rdata = stat_byte;
      else if (sel_data) bus_rdata = data_q;
    end
  end

  assign irq = ctrl_q[CB_EN] && ctrl_q[CB_IE] && done_f;
  assign sck = busy ? sck_lvl : ctrl_q[CB_POL];

  assert_collide_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !done) |=> (busy && $stable(data_q)));
  assert_disabled_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ctrl_q[CB_EN] && !busy) |=> !busy);
  assert_done_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done_f);

endmodule

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;

  localparam logic [7:0] A_CTRL = 8'h2D;
  localparam logic [7:0] A_STAT = 8'h2E;
  localparam logic [7:0] A_DATA = 8'h2F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_ack = 1'b0;
  logic       irq, sck, mosi;
  logic       miso;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  // slave model
  logic [7:0] s_tx = '0;
  logic [7:0] s_rx = '0;
  int         s_idx = 0;
  bit         s_lsb = 0, s_cpol = 0, s_cpha = 0;

  function automatic int bpos(input int i);
    return s_lsb ? i : 7 - i;
  endfunction

  always_comb miso = (s_idx < 8) ? s_tx[bpos(s_idx)] : 1'b0;

  task automatic slave_sample();
    if (s_idx < 8) begin
      s_rx[bpos(s_idx)] = mosi;
      s_idx = s_idx + 1;
    end
  endtask

  always @(posedge sck) if (s_cpol == s_cpha) slave_sample();
  always @(negedge sck) if (s_cpol != s_cpha) slave_sample();

  function automatic int exp_cycles(input logic [1:0] r);
    case (r)
      2'd0: return 32;
      2'd1: return 128;
      2'd2: return 512;
      default: return 1024;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic read_expect(input logic [7:0] a, input logic [7:0] e, input string req);
    logic [7:0] d;
    bus_read(a, d);
    check(d == e, req, d, e);
  endtask

  task automatic set_mode(input logic [7:0] ctrl);
    bus_write(A_CTRL, ctrl);
    s_cpol = ctrl[3]; s_cpha = ctrl[2]; s_lsb = ctrl[5];
    s_idx = 0; s_rx = '0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 3000) begin
      @(posedge clk); #1 n++;
    end
  endtask

  function automatic logic [7:0] mk_ctrl(input bit ie, input bit lsb, input bit cpol,
                                         input bit cpha, input logic [1:0] r);
    return {ie, 1'b1, lsb, 1'b1, cpol, cpha, r};
  endfunction

  task automatic run_xfer(input logic [1:0] r, input bit cpol, input bit cpha,
                          input bit lsb, input logic [7:0] txb, input logic [7:0] sb);
    int n;
    set_mode(mk_ctrl(1'b1, lsb, cpol, cpha, r));
    check(sck == cpol, "R5 idle sck", sck, cpol);
    s_tx = sb;
    bus_write(A_DATA, txb);
    wait_irq(n);
    check(n == exp_cycles(r), "R4 cycles to complete", n, exp_cycles(r));
    check(s_rx == txb, "R5 byte seen by slave", s_rx, txb);
    check(sck == cpol, "R5 sck back to idle", sck, cpol);
    read_expect(A_STAT, 8'h80, "R3 complete flag");
    read_expect(A_DATA, sb, "R3 received byte");
    read_expect(A_STAT, 8'h00, "R7 cleared after sequence");
    check(irq == 1'b0, "R8 irq low after clear", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(sck == 1'b0, "R1 sck", sck, 0);
    read_expect(A_CTRL, 8'h00, "R1 ctrl");
    read_expect(A_STAT, 8'h00, "R1 status");
    read_expect(A_DATA, 8'h00, "R1 data");

    // R2 map and readback
    bus_write(A_CTRL, 8'hBC);
    read_expect(A_CTRL, 8'hBC, "R2 ctrl readback");
    read_expect(8'h30, 8'h00, "R2 unmapped above");
    read_expect(8'h2C, 8'h00, "R2 unmapped below");

    // R10 enable clear: byte stored, no transfer
    set_mode(8'h18);
    bus_write(A_DATA, 8'h5A);
    repeat (300) @(posedge clk);
    #1 check(sck == 1'b1, "R10 sck idle", sck, 1);
    check(s_idx == 0, "R10 no sck edges", s_idx, 0);
    read_expect(A_STAT, 8'h00, "R10 no flag");
    read_expect(A_DATA, 8'h5A, "R10 byte stored");

    // directed: each rate, each mode
    run_xfer(2'd0, 0, 0, 0, 8'hA5, 8'h3C);
    run_xfer(2'd1, 0, 1, 1, 8'h81, 8'h7E);
    run_xfer(2'd2, 1, 0, 0, 8'h01, 8'hF0);
    run_xfer(2'd3, 1, 1, 1, 8'hC3, 8'h0F);

    // R6 collision mid-transfer
    set_mode(mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 2'd1));
    s_tx = 8'h96;
    bus_write(A_DATA, 8'h4D);
    repeat (40) @(posedge clk);
    bus_write(A_DATA, 8'hFF);
    wait_irq(n);
    check(s_rx == 8'h4D, "R6 transfer undisturbed", s_rx, 8'h4D);
    read_expect(A_STAT, 8'hC0, "R6 collision and complete");
    read_expect(A_DATA, 8'h96, "R6 data is received byte");
    read_expect(A_STAT, 8'h00, "R7 both flags cleared");

    // R7 data access without marking read keeps flag; R9 ack clears
    set_mode(mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
    s_tx = 8'h22;
    bus_write(A_DATA, 8'h11);
    wait_irq(n);
    read_expect(A_DATA, 8'h22, "R7 data read");
    read_expect(A_STAT, 8'h80, "R7 flag kept without marking read");
    check(irq == 1'b1, "R8 irq while flag set", irq, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(posedge clk); #1 irq_ack = 1'b0;
    check(irq == 1'b0, "R9 irq after ack", irq, 0);
    read_expect(A_STAT, 8'h00, "R9 flag cleared by ack");

    // R8 interrupt enable off
    set_mode(mk_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 2'd0));
    s_tx = 8'h5C;
    bus_write(A_DATA, 8'h33);
    repeat (40) @(posedge clk);
    #1 check(irq == 1'b0, "R8 irq masked", irq, 0);
    read_expect(A_STAT, 8'h80, "R8 flag set while masked");
    read_expect(A_DATA, 8'h5C, "R3 masked receive");

    // random transfers
    for (int i = 0; i < 16; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      run_xfer(rv[1:0], rv[2], rv[3], rv[4], rv[15:8], rv[23:16]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule